// File: doc/BRIEF.md
# Serial Bus Response Receiver

This block runs the master side of a two-wire serial bus once a command frame has gone out. It clocks the bus one bit per system clock and watches the shared data line for the slave's reply. When the reply comes, the block decodes it and collects read data of the requested width. It checks the reply's 4-bit CRC and reports one outcome.

The line is negative-active, so a low line carries a logical 1. A slave that answers "busy" is polled again. Before each poll frame, the block drives the line idle-high for a fixed number of clocks. The master asks for a response through a valid/ready request port. The request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_rd` and `req_size` are sampled only on that cycle. `req_ready` stays low from acceptance until the result cycle, so that is the only back-pressure. The result is a single-cycle `done` pulse carrying `status` and `rdata`. The result has no back-pressure, and the consumer must take it on that cycle.

Top module: `serial_rsp_rx`

## Requirements
- R1: After reset, and whenever no request is in progress, `req_ready` is high and `bus_clk`, `bus_doe` and `done` are low. An accepted request drops `req_ready` and starts bus clocking on the next cycle.
- R2: In the start search, every cycle gives one bus clock with `bus_doe` low. A low `bus_din` (logical 1) is the start bit. The start may arrive on any of the first 1000 sampled clocks.
- R3: If 1000 samples pass with no start bit, the block gives 20 more drain clocks with `bus_doe` low, then reports status 4 (timeout).
- R4: After the start bit, four bits are received, each the inverse of the line: a 2-bit slave ID, then a 2-bit response code. Code 0 means ACK, 1 means BUSY, 2 means general error and 3 means master-CRC error.
- R5: On ACK for a read, data bits follow. `req_size` 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. The bits arrive MSB first and are right-aligned in `rdata` with the upper bits zero. On ACK for a write, no data bits follow.
- R6: Four CRC bits come last, MSB first. They are compared with a CRC of x^4+x^2+x+1, started from zero, over a leading 1, the ID, the code and the data bits. On a mismatch, status 5 is reported on the cycle after the last CRC bit.
- R7: A response with a matching CRC is followed by 100 priming clocks with `bus_doe` low, then status 0 with valid `rdata`.
- R8: After a BUSY header, the block drives the line high for 100 clocks. It then drives 10 clocks carrying the poll frame: a start bit followed by the 9-bit value 0x02A, MSB first, each put on the line inverted. Next come 16 high echo clocks, and then the start search begins again.
- R9: The first 100 BUSY responses of a request are each polled as in R8. The 101st reports status 1 on the cycle after its header, without polling.
- R10: On response code 2 or 3, the block gives 4 more clocks with `bus_doe` low, then reports status 2 or status 3 respectively.
- R11: `done` is a one-cycle pulse on the cycle after the last bus clock. On that cycle `bus_clk` is low and `status` (and `rdata` on success) is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one bus bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request to receive a response |
| req_ready | output | 1 | High while idle; request accepted when both high |
| req_rd | input | 1 | 1 = read access (data expected), 0 = write |
| req_size | input | 2 | Access size: 0 = 8, 1 = 16, 2/3 = 32 bits |
| bus_clk | output | 1 | High on each cycle that is a bus clock |
| bus_din | input | 1 | Data line as seen by the master (raw level) |
| bus_dout | output | 1 | Level driven on the data line when enabled |
| bus_doe | output | 1 | Drive enable for the data line |
| done | output | 1 | One-cycle result pulse |
| status | output | 3 | 0 ok, 1 stuck busy, 2 error, 3 CRC error reported by slave, 4 timeout, 5 response CRC mismatch |
| rdata | output | 32 | Received read data, right-aligned |

## Verification
Every bus bit occupies exactly one cycle, and each outcome depends only on the bits that came before it. The bench lays out each transaction as a queue with one entry per cycle after acceptance. Each entry holds the line level to drive and the expected clock, enable, drive level, `done` and `req_ready`. The result entry falls 1 cycle after the last CRC bit on a mismatch, 101 cycles after it on success, 5 cycles after the code bits on an error code, and 21 cycles after the 1000th empty sample on a timeout. Inputs are applied and outputs compared on the falling edge, one queue entry per cycle, so every result is checked on exactly its due cycle.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_HDR, S_DATA, S_CRC, S_SKIP,
    S_DRAIN, S_HOLD, S_POLL, S_ECHO, S_PRIME
  } srx_state_e;

  localparam logic [2:0] ST_OK   = 3'd0;
  localparam logic [2:0] ST_BUSY = 3'd1;
  localparam logic [2:0] ST_ERRA = 3'd2;
  localparam logic [2:0] ST_ERRC = 3'd3;
  localparam logic [2:0] ST_TMO  = 3'd4;
  localparam logic [2:0] ST_CRC  = 3'd5;

  localparam logic [1:0] RC_ACK  = 2'd0;
  localparam logic [1:0] RC_BUSY = 2'd1;
  localparam logic [1:0] RC_ERRA = 2'd2;
  localparam logic [1:0] RC_ERRC = 2'd3;

  // one serial step of x^4+x^2+x+1
  function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ (fb ? 4'b0111 : 4'b0000);
  endfunction

endpackage

// File: rtl/srx_crc4.sv
module srx_crc4
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seed,
  input  logic       en,
  input  logic       din,
  output logic [3:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n)    crc <= 4'h0;
    else if (seed) crc <= crc4_step(4'h0, 1'b1);
    else if (en)   crc <= crc4_step(crc, din);
  end

  // R6: the check value only moves while response bits are fed in
  p_crc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed && !en) |=> $stable(crc));
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else if (en)       q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/serial_rsp_rx.sv
module serial_rsp_rx
  import srx_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 1000,
  parameter int DRAIN_CLKS   = 20,
  parameter int HOLD_CLKS    = 100,
  parameter int ECHO_CLKS    = 16,
  parameter int PRIME_CLKS   = 100,
  parameter int SKIP_CLKS    = 4,
  parameter int MAX_BUSY     = 100,
  parameter int POLL_BITS    = 9,
  parameter logic [POLL_BITS-1:0] POLL_CODE = 9'h02A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_rd,
  input  logic [1:0]  req_size,
  output logic        bus_clk,
  input  logic        bus_din,
  output logic        bus_dout,
  output logic        bus_doe,
  output logic        done,
  output logic [2:0]  status,
  output logic [31:0] rdata
);
  localparam int DATA_W   = 32;
  localparam int HDR_BITS = 4;
  localparam int CRC_BITS = 4;
  localparam int FRAME_W  = POLL_BITS + 1;
  localparam int CNT_MAX  = TIMEOUT_CLKS + DRAIN_CLKS + HOLD_CLKS + ECHO_CLKS
                          + PRIME_CLKS + SKIP_CLKS + FRAME_W + DATA_W;
  localparam int CNT_W    = $clog2(CNT_MAX);
  localparam int BUSY_W   = $clog2(MAX_BUSY + 1);
  localparam int LEN_W    = $clog2(DATA_W) + 1;
  localparam logic [FRAME_W-1:0] POLL_FRAME = {1'b1, POLL_CODE};

  srx_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BUSY_W-1:0] busy_cnt;
  logic              rd_q;
  logic [LEN_W-1:0]  dlen_q;
  logic              done_q;
  logic [2:0]        status_q;

  logic                 bit_in, start_hit;
  logic [CRC_BITS-2:0]  sh_q;
  logic [3:0]           crc_q;
  logic [DATA_W-1:0]    data_q;
  logic [1:0]           code;
  logic [CRC_BITS-1:0]  crc_rx;
  logic [FRAME_W-1:0]   poll_sh;

  function automatic logic [LEN_W-1:0] size_len(input logic [1:0] s);
    case (s)
      2'd0:    return LEN_W'(8);
      2'd1:    return LEN_W'(16);
      default: return LEN_W'(DATA_W);
    endcase
  endfunction

  assign bit_in    = ~bus_din;  // line is negative-active
  assign start_hit = (state == S_WAIT) && bit_in;
  assign code      = {sh_q[0], bit_in};
  assign crc_rx    = {sh_q, bit_in};

  srx_crc4 u_crc (
    .clk(clk), .rst_n(rst_n), .seed(start_hit),
    .en((state == S_HDR) || (state == S_DATA)), .din(bit_in), .crc(crc_q)
  );

  srx_shift #(.W(CRC_BITS-1)) u_hdr (
    .clk(clk), .rst_n(rst_n), .clr(1'b0),
    .en((state == S_HDR) || (state == S_CRC)), .din(bit_in), .q(sh_q)
  );

  srx_shift #(.W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .clr(start_hit),
    .en(state == S_DATA), .din(bit_in), .q(data_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      busy_cnt <= '0;
      rd_q     <= 1'b0;
      dlen_q   <= '0;
      done_q   <= 1'b0;
      status_q <= ST_OK;
    end else begin
      done_q <= 1'b0;
      cnt    <= cnt + 1'b1;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (req_valid) begin
            state    <= S_WAIT;
            rd_q     <= req_rd;
            dlen_q   <= size_len(req_size);
            busy_cnt <= '0;
          end
        end
        S_WAIT: begin
          if (bit_in) begin
            state <= S_HDR; cnt <= '0;
          end else if (cnt == CNT_W'(TIMEOUT_CLKS - 1)) begin
            state <= S_DRAIN; cnt <= '0;
          end
        end
        S_HDR: if (cnt == CNT_W'(HDR_BITS - 1)) begin
          cnt <= '0;
          case (code)
            RC_ACK:  state <= rd_q ? S_DATA : S_CRC;
            RC_BUSY: begin
              if (busy_cnt == BUSY_W'(MAX_BUSY)) begin
                state <= S_IDLE; done_q <= 1'b1; status_q <= ST_BUSY;
              end else begin
                busy_cnt <= busy_cnt + 1'b1;
                state    <= S_HOLD;
              end
            end
            default: begin
              state    <= S_SKIP;
              status_q <= (code == RC_ERRA) ? ST_ERRA : ST_ERRC;
            end
          endcase
        end
        S_DATA: if (cnt == CNT_W'(dlen_q) - 1'b1) begin
          state <= S_CRC; cnt <= '0;
        end
        S_CRC: if (cnt == CNT_W'(CRC_BITS - 1)) begin
          cnt <= '0;
          if (crc_rx == crc_q) state <= S_PRIME;
          else begin
            state <= S_IDLE; done_q <= 1'b1; status_q <= ST_CRC;
          end
        end
        S_PRIME: if (cnt == CNT_W'(PRIME_CLKS - 1)) begin
          state <= S_IDLE; done_q <= 1'b1; status_q <= ST_OK;
        end
        S_SKIP: if (cnt == CNT_W'(SKIP_CLKS - 1)) begin
          state <= S_IDLE; done_q <= 1'b1;
        end
        S_DRAIN: if (cnt == CNT_W'(DRAIN_CLKS - 1)) begin
          state <= S_IDLE; done_q <= 1'b1; status_q <= ST_TMO;
        end
        S_HOLD: if (cnt == CNT_W'(HOLD_CLKS - 1)) begin
          state <= S_POLL; cnt <= '0;
        end
        S_POLL: if (cnt == CNT_W'(FRAME_W - 1)) begin
          state <= S_ECHO; cnt <= '0;
        end
        S_ECHO: if (cnt == CNT_W'(ECHO_CLKS - 1)) begin
          state <= S_WAIT; cnt <= '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign poll_sh   = POLL_FRAME << cnt;
  assign req_ready = (state == S_IDLE);
  assign bus_clk   = (state != S_IDLE);
  assign bus_doe   = (state == S_HOLD) || (state == S_POLL) || (state == S_ECHO);
  assign bus_dout  = (state == S_POLL) ? ~poll_sh[FRAME_W-1] : 1'b1;
  assign done      = done_q;
  assign status    = status_q;
  assign rdata     = data_q;

  // R1: an accepted request leaves idle and starts clocking
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && bus_clk));
  // R1: idle means a quiet bus
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_clk && !bus_doe));
  // R2: start search never outlives its window
  p_wait_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> (cnt < CNT_W'(TIMEOUT_CLKS)));
  // R9: busy tally bounded
  p_busy_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= BUSY_W'(MAX_BUSY));
  // R11: one-cycle pulse, reported from idle with a legal code
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !bus_clk && status <= ST_CRC));
endmodule

// File: tb/serial_rsp_rx_test.sv
module serial_rsp_rx_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_rd, bus_clk, bus_din, bus_dout, bus_doe, done;
  logic [1:0] req_size;
  logic [2:0] status;
  logic [31:0] rdata;

  serial_rsp_rx uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_size(req_size), .bus_clk(bus_clk), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .done(done), .status(status), .rdata(rdata)
  );

  typedef struct packed {
    logic c; logic doe; logic dout; logic dn;
    logic [2:0] st; logic chk_rd; logic [31:0] rd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic  drv_q[$];
  int n_chk = 0, n_fail = 0;

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] ex);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, ex, $time);
    end
  endtask

  task automatic cyc(input logic drv, input logic doe, input logic dout, input string tag);
    drv_q.push_back(drv);
    exp_q.push_back('{1'b1, doe, dout, 1'b0, 3'd0, 1'b0, 32'd0});
    tag_q.push_back(tag);
  endtask

  task automatic fin(input logic [2:0] st, input logic chk, input logic [31:0] rd, input string tag);
    drv_q.push_back(1'b1);
    exp_q.push_back('{1'b0, 1'b0, 1'b0, 1'b1, st, chk, rd});
    tag_q.push_back(tag);
  endtask

  function automatic logic [3:0] crc_of(input logic [63:0] v, input int n);
    logic [3:0] c = 4'h0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = c[3] ^ v[i];
      c = {c[2:0], 1'b0} ^ (fb ? 4'b0111 : 4'b0000);
    end
    return c;
  endfunction

  // R2: idle-high samples before a start bit
  task automatic gap(input int g);
    for (int i = 0; i < g; i++) cyc(1'b1, 1'b0, 1'b0, "R2");
  endtask

  // R4: start bit, then ID and code, line inverted
  task automatic header(input logic [1:0] id, input logic [1:0] code);
    logic [3:0] b = {id, code};
    cyc(1'b0, 1'b0, 1'b0, "R2");
    for (int i = 3; i >= 0; i--) cyc(~b[i], 1'b0, 1'b0, "R4");
  endtask

  // R8: idle high, poll frame, echo
  task automatic busy_once(input int g, input logic [1:0] id);
    logic [9:0] fr = {1'b1, 9'h02A};
    gap(g);
    header(id, 2'd1);
    for (int i = 0; i < 100; i++) cyc(1'b1, 1'b1, 1'b1, "R8");
    for (int i = 9; i >= 0; i--) cyc(1'b1, 1'b1, ~fr[i], "R8");
    for (int i = 0; i < 16; i++) cyc(1'b1, 1'b1, 1'b1, "R8");
  endtask

  function automatic int len_of(input logic rd, input logic [1:0] sz);
    if (!rd) return 0;
    return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
  endfunction

  task automatic ack(input logic rd, input logic [1:0] sz, input int g,
                     input logic [1:0] id, input logic [31:0] d, input logic bad);
    int nd = len_of(rd, sz);
    logic [63:0] v = {59'd0, 1'b1, id, 2'd0};
    logic [3:0] c;
    logic [31:0] dm = (nd == 32) ? d : (nd == 0) ? 32'd0 : (d & ((32'd1 << nd) - 1));
    gap(g);
    header(id, 2'd0);
    for (int i = nd - 1; i >= 0; i--) begin
      cyc(~d[i], 1'b0, 1'b0, "R5");
      v = {v[62:0], d[i]};
    end
    c = crc_of(v, 5 + nd);
    if (bad) c = c ^ 4'h5;
    for (int i = 3; i >= 0; i--) cyc(~c[i], 1'b0, 1'b0, "R6");
    if (bad) fin(3'd5, 1'b0, 32'd0, "R6");
    else begin
      for (int i = 0; i < 100; i++) cyc(1'b1, 1'b0, 1'b0, "R7");
      fin(3'd0, 1'b1, dm, "R7");
    end
  endtask

  task automatic run(input logic rd, input logic [1:0] sz);
    exp_t e; string t;
    @(negedge clk);
    check(req_ready === 1'b1, "R1", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_rd = rd; req_size = sz;
    @(posedge clk); #1 req_valid = 1'b0;
    while (exp_q.size() > 0) begin
      @(negedge clk);
      bus_din = drv_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({bus_clk, bus_doe, bus_doe & bus_dout, done, req_ready} ===
            {e.c, e.doe, e.doe & e.dout, e.dn, e.dn}, t,
            {59'd0, bus_clk, bus_doe, bus_doe & bus_dout, done, req_ready},
            {59'd0, e.c, e.doe, e.doe & e.dout, e.dn, e.dn});
      if (e.dn) begin
        check(status === e.st, (t == "R7") ? "R11 status" : t, {61'd0, status}, {61'd0, e.st});
        if (e.chk_rd) check(rdata === e.rd, "R5 rdata", {32'd0, rdata}, {32'd0, e.rd});
      end
    end
    bus_din = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_rd = 1'b0; req_size = 2'd0; bus_din = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check({req_ready, bus_clk, bus_doe, done} === 4'b1000, "R1 reset",
          {60'd0, req_ready, bus_clk, bus_doe, done}, 64'h8);
    rst_n = 1'b1;

    ack(1'b0, 2'd2, 3, 2'd1, 32'd0, 1'b0);          run(1'b0, 2'd2); // write ACK
    ack(1'b1, 2'd0, 0, 2'd2, 32'hDEAD_BEA5, 1'b0);  run(1'b1, 2'd0); // read 8
    ack(1'b1, 2'd1, 5, 2'd3, 32'h1234_C3A9, 1'b0);  run(1'b1, 2'd1); // read 16
    ack(1'b1, 2'd3, 2, 2'd0, 32'h8000_0001, 1'b0);  run(1'b1, 2'd3); // size 3 is 32
    busy_once(1, 2'd1); busy_once(0, 2'd1);                          // R8
    ack(1'b1, 2'd2, 4, 2'd1, 32'hF0E1_D2C3, 1'b0);  run(1'b1, 2'd2);
    ack(1'b1, 2'd2, 1, 2'd2, 32'h5A5A_0FF0, 1'b1);  run(1'b1, 2'd2); // R6 bad CRC
    ack(1'b0, 2'd0, 1, 2'd1, 32'd0, 1'b1);          run(1'b0, 2'd0); // R6 write
    ack(1'b1, 2'd0, 999, 2'd0, 32'h0000_007E, 1'b0); run(1'b1, 2'd0); // R2 last slot

    // R10: error codes
    gap(2); header(2'd1, 2'd2);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, "R10");
    fin(3'd2, 1'b0, 32'd0, "R10"); run(1'b0, 2'd1);
    gap(0); header(2'd3, 2'd3);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, "R10");
    fin(3'd3, 1'b0, 32'd0, "R10"); run(1'b1, 2'd2);

    // R3: timeout then drain
    gap(1000);
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 1'b0, "R3");
    fin(3'd4, 1'b0, 32'd0, "R3"); run(1'b1, 2'd0);

    // R9: 100 polled busies, the 101st gives up
    for (int k = 0; k < 100; k++) busy_once(k % 3, 2'd2);
    gap(1); header(2'd2, 2'd1);
    fin(3'd1, 1'b0, 32'd0, "R9"); run(1'b0, 2'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule